// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit collects the interrupt requests of a UART, ranks them, and shows the winner as a 4-bit identification code to a register read port. It also drives a single interrupt line. The receiver side supplies three level requests: line status, received data available and character timeout. The unit derives two more requests itself. The first is the transmit-empty request, built from the transmit FIFO empty flag and its occupancy. The second is the modem-status request, built from the four modem input pins. The bus side provides one-cycle strobes for three accesses: an identification read, a modem status read and a transmit holding write.

The transmit-empty request is deliberately slow after a quiet period. Suppose the transmit FIFO empties without ever having held two characters at once since the last empty event (start-up counts as such an event). The request then waits for a programmable number of bit times, given as `delay_bits` and counted on `bit_tick`. That count is one character time without the stop bit. This gives software room to queue data before it is interrupted. If the FIFO did reach two characters, the request is raised as soon as the FIFO empties.

The modem pins are re-timed by a two-stage synchronizer before their edges are detected. The detected changes gather in four sticky delta bits, which a modem status read returns and clears.

Top module: `uart_irq_ident`

## Requirements
- R1: With no source pending, `iir_code` is 4'b0001 and `irq` is low; this is also the state right after reset.
- R2: Bit 0 of `iir_code` is 0 whenever `irq` is high. The sources rank from highest to lowest as follows: line status 4'b0110, received data 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, modem status 4'b0000.
- R3: `iir_code` only ever takes the values 0001, 0110, 0100, 1100, 0010 or 0000.
- R4: When the FIFO becomes empty without having held two or more characters at once since the previous raise (start-up included), transmit empty is raised only on the `delay_bits`-th `bit_tick` seen while empty. It is visible the cycle after that tick.
- R5: When the FIFO has held two or more characters (`tx_level` ≥ 2) and then `tx_empty` rises, transmit empty is pending one clock later.
- R6: A `thr_wr` strobe clears transmit empty. The request stays clear while the FIFO remains empty, whatever ticks arrive.
- R7: An `iir_rd` strobe clears transmit empty only when 4'b0010 is the code shown in that cycle. A read while a higher source is shown leaves it pending.
- R8: `msr_delta` bit 0 records a change of CTS, bit 1 a change of DSR, bit 2 a rising edge of RI, and bit 3 a change of DCD. A falling RI sets nothing. A pin change appears in `msr_delta` three clocks after it reaches the pin.
- R9: An `msr_rd` strobe clears `msr_delta` and the modem request. A change detected in the same cycle as the read is kept in `msr_delta`.
- R10: Raising transmit empty forgets the two-character history. A later empty after an occupancy of only one character again waits the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stat_req | input | 1 | Line status request (level) |
| rx_avail_req | input | 1 | Received data available request (level) |
| rx_timeout_req | input | 1 | Character timeout request (level) |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| bit_tick | input | 1 | One pulse per bit time |
| delay_bits | input | CNT_W | Bit times of the start-up hold-off |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| dsr_pin | input | 1 | Data-set-ready pin, asynchronous |
| ri_pin | input | 1 | Ring indicator pin, asynchronous |
| dcd_pin | input | 1 | Carrier detect pin, asynchronous |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_code | output | 4 | Identification code |
| irq | output | 1 | Interrupt line |
| msr_delta | output | 4 | Modem change bits (DCD, RI, DSR, CTS from bit 3 down) |

## Verification
The bench counts the hold-off tick by tick, so a design that raised transmit empty one tick early or late, or raised it at once after start-up, is caught. It reads the identification register while line status outranks transmit empty; a design that cleared on any read would lose the pending transmit-empty request. It empties the FIFO again after a one-character fill that follows an immediate raise; a design that kept the two-character history would raise at once. It also places a modem status read in the very cycle a new DSR change is detected, and checks for a falling RI; a design that dropped the new change, or flagged both RI edges, shows the wrong delta bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_LINE    = 4'b0110,
        IID_RXDATA  = 4'b0100,
        IID_TIMEOUT = 4'b1100,
        IID_TXEMPTY = 4'b0010,
        IID_MODEM   = 4'b0000
    } iid_e;

    typedef enum logic [1:0] {
        TXS_BUSY,
        TXS_WAIT,
        TXS_RAISED,
        TXS_DONE
    } txs_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } irq_src_t;

    localparam int N_MDM   = 4;
    localparam int MDM_CTS = 0;
    localparam int MDM_DSR = 1;
    localparam int MDM_RI  = 2;
    localparam int MDM_DCD = 3;

    function automatic iid_e pick_source(irq_src_t s);
        if (s.line)         return IID_LINE;
        else if (s.rxdata)  return IID_RXDATA;
        else if (s.timeout) return IID_TIMEOUT;
        else if (s.txempty) return IID_TXEMPTY;
        else if (s.modem)   return IID_MODEM;
        else                return IID_NONE;
    endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t src,
    output iid_e     code,
    output logic     pending
);
    always_comb begin
        code    = pick_source(src);
        pending = (code != IID_NONE);
    end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_empty,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] delay_bits,
    input  logic             thr_wr,
    input  logic             iir_rd_top,
    output logic             thre_pend
);
    localparam logic [LVL_W-1:0] TWO_CHARS = LVL_W'(2);

    txs_e             st;
    logic [CNT_W-1:0] cnt;
    logic             two_seen;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc   = {1'b0, cnt} + 1'b1;
    assign thre_pend = (st == TXS_RAISED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TXS_BUSY;
            cnt      <= '0;
            two_seen <= 1'b0;
        end else begin
            if (tx_level >= TWO_CHARS)
                two_seen <= 1'b1;
            case (st)
                TXS_BUSY: begin
                    if (tx_empty) begin
                        if (two_seen) begin
                            st       <= TXS_RAISED;
                            two_seen <= 1'b0;
                        end else begin
                            st  <= TXS_WAIT;
                            cnt <= '0;
                        end
                    end
                end
                TXS_WAIT: begin
                    if (!tx_empty)
                        st <= TXS_BUSY;
                    else if (thr_wr)
                        st <= TXS_DONE;
                    else if (bit_tick) begin
                        if (cnt_inc >= {1'b0, delay_bits}) begin
                            st       <= TXS_RAISED;
                            two_seen <= 1'b0;
                        end else begin
                            cnt <= cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                TXS_RAISED: begin
                    if (!tx_empty)
                        st <= TXS_BUSY;
                    else if (thr_wr || iir_rd_top)
                        st <= TXS_DONE;
                end
                default: begin
                    if (!tx_empty)
                        st <= TXS_BUSY;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MDM-1:0] pins,
    input  logic             msr_rd,
    output logic [N_MDM-1:0] chg,
    output logic [N_MDM-1:0] delta
);
    logic [N_MDM-1:0] synced;
    logic [N_MDM-1:0] prev;

    for (genvar i = 0; i < N_MDM; i++) begin : g_pin
        logic [SYNC_STAGES-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[SYNC_STAGES-2:0], pins[i]};
        end
        assign synced[i] = shreg[SYNC_STAGES-1];

        if (i == MDM_RI) begin : g_rise
            assign chg[i] = synced[i] & ~prev[i];
        end else begin : g_any
            assign chg[i] = synced[i] ^ prev[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            delta <= '0;
        end else begin
            prev  <= synced;
            delta <= msr_rd ? chg : (delta | chg);
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W       = 5,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_stat_req,
    input  logic             rx_avail_req,
    input  logic             rx_timeout_req,
    input  logic             tx_empty,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] delay_bits,
    input  logic             cts_pin,
    input  logic             dsr_pin,
    input  logic             ri_pin,
    input  logic             dcd_pin,
    input  logic             iir_rd,
    input  logic             msr_rd,
    input  logic             thr_wr,
    output logic [3:0]       iir_code,
    output logic             irq,
    output logic [3:0]       msr_delta
);
    irq_src_t         src;
    iid_e             code;
    logic             pending;
    logic             thre_pend;
    logic             iir_rd_top;
    logic [N_MDM-1:0] mdm_pins;
    logic [N_MDM-1:0] mdm_chg;
    logic [N_MDM-1:0] mdm_delta;

    always_comb begin
        mdm_pins          = '0;
        mdm_pins[MDM_CTS] = cts_pin;
        mdm_pins[MDM_DSR] = dsr_pin;
        mdm_pins[MDM_RI]  = ri_pin;
        mdm_pins[MDM_DCD] = dcd_pin;
    end

    assign iir_rd_top = iir_rd && (code == IID_TXEMPTY);

    uart_irq_thre #(.LVL_W(LVL_W), .CNT_W(CNT_W)) thre_i (
        .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_level(tx_level),
        .bit_tick(bit_tick), .delay_bits(delay_bits), .thr_wr(thr_wr),
        .iir_rd_top(iir_rd_top), .thre_pend(thre_pend)
    );

    uart_irq_modem #(.SYNC_STAGES(SYNC_STAGES)) modem_i (
        .clk(clk), .rst(rst), .pins(mdm_pins), .msr_rd(msr_rd),
        .chg(mdm_chg), .delta(mdm_delta)
    );

    always_comb begin
        src.line    = line_stat_req;
        src.rxdata  = rx_avail_req;
        src.timeout = rx_timeout_req;
        src.txempty = thre_pend;
        src.modem   = |mdm_delta;
    end

    uart_irq_prio prio_i (.src(src), .code(code), .pending(pending));

    assign iir_code  = code;
    assign irq       = pending;
    assign msr_delta = mdm_delta;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_stat_req,
    input logic       rx_avail_req,
    input logic       tx_empty,
    input logic       iir_rd,
    input logic       msr_rd,
    input logic       thr_wr,
    input logic [3:0] iir_code,
    input logic       irq,
    input logic [3:0] msr_delta,
    input logic [3:0] mdm_chg,
    input logic       thre_pend
);
    p_idle_code_r1: assert property (@(posedge clk) disable iff (rst)
        !irq |-> iir_code == 4'b0001);

    p_line_top_r2: assert property (@(posedge clk) disable iff (rst)
        line_stat_req |-> (iir_code == 4'b0110 && irq));

    p_rx_over_lower_r2: assert property (@(posedge clk) disable iff (rst)
        (!line_stat_req && rx_avail_req) |-> iir_code == 4'b0100);

    p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (iir_code == 4'b0110 || iir_code == 4'b0100 ||
                 iir_code == 4'b1100 || iir_code == 4'b0010 ||
                 iir_code == 4'b0000));

    p_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !thre_pend);

    p_read_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && thre_pend && iir_code != 4'b0010 && !thr_wr && tx_empty)
        |=> thre_pend);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        msr_rd |=> msr_delta == $past(mdm_chg));

    p_sticky_delta_r9: assert property (@(posedge clk) disable iff (rst)
        !msr_rd |=> (msr_delta & $past(msr_delta)) == $past(msr_delta));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk(clk), .rst(rst), .line_stat_req(line_stat_req),
    .rx_avail_req(rx_avail_req), .tx_empty(tx_empty), .iir_rd(iir_rd),
    .msr_rd(msr_rd), .thr_wr(thr_wr), .iir_code(iir_code), .irq(irq),
    .msr_delta(msr_delta), .mdm_chg(mdm_chg), .thre_pend(thre_pend)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 5;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] HOLD = 4'd8;

    // {line, rx, timeout, expected code} while transmit empty is pending
    localparam logic [6:0] VEC [8] = '{
        {3'b000, 4'b0010}, {3'b001, 4'b1100},
        {3'b010, 4'b0100}, {3'b011, 4'b0100},
        {3'b100, 4'b0110}, {3'b101, 4'b0110},
        {3'b110, 4'b0110}, {3'b111, 4'b0110}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_stat_req = 0, rx_avail_req = 0, rx_timeout_req = 0;
    logic tx_empty = 1'b1;
    logic [LVL_W-1:0] tx_level = '0;
    logic bit_tick = 0;
    logic [CNT_W-1:0] delay_bits = HOLD;
    logic cts_pin = 0, dsr_pin = 0, ri_pin = 0, dcd_pin = 0;
    logic iir_rd = 0, msr_rd = 0, thr_wr = 0;
    logic [3:0] iir_code;
    logic irq;
    logic [3:0] msr_delta;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .line_stat_req(line_stat_req),
        .rx_avail_req(rx_avail_req), .rx_timeout_req(rx_timeout_req),
        .tx_empty(tx_empty), .tx_level(tx_level), .bit_tick(bit_tick),
        .delay_bits(delay_bits), .cts_pin(cts_pin), .dsr_pin(dsr_pin),
        .ri_pin(ri_pin), .dcd_pin(dcd_pin), .iir_rd(iir_rd),
        .msr_rd(msr_rd), .thr_wr(thr_wr), .iir_code(iir_code),
        .irq(irq), .msr_delta(msr_delta)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // checks {irq, iir_code}
    task automatic check_code(input string req, input logic [3:0] exp);
        check(req, {irq, iir_code}, {exp != 4'b0001, exp});
    endtask

    task automatic check_delta(input string req, input logic [3:0] exp);
        check(req, {1'b0, msr_delta}, {1'b0, exp});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(posedge clk);
            #1 bit_tick = 1'b0;
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(posedge clk);
        #1 sig = 1'b0;
    endtask

    task automatic pin_then_wait(ref logic pin, input logic val);
        @(negedge clk) pin = val;
        cycles(3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(3);
        check_code("R1 reset", 4'b0001);
        check_delta("R1 reset delta", 4'b0000);
        @(negedge clk) rst = 1'b0;
        cycles(2);

        // R4: start-up hold-off
        ticks(HOLD - 1);
        check_code("R4 hold-off before last tick", 4'b0001);
        ticks(1);
        check_code("R4 raise on last tick", 4'b0010);

        // R2 / R3 priority table
        foreach (VEC[i]) begin
            @(negedge clk);
            {line_stat_req, rx_avail_req, rx_timeout_req} = VEC[i][6:4];
            #1 check_code("R2 R3 priority vector", VEC[i][3:0]);
        end
        @(negedge clk) {line_stat_req, rx_avail_req, rx_timeout_req} = 3'b000;

        // R7: read while line status is on top keeps transmit empty
        @(negedge clk) line_stat_req = 1'b1;
        pulse(iir_rd);
        @(negedge clk) line_stat_req = 1'b0;
        #1 check_code("R7 read under higher source keeps", 4'b0010);
        pulse(iir_rd);
        check_code("R7 read on top clears", 4'b0001);

        // R6: one-character fill, delayed raise, write clears
        @(negedge clk) begin tx_empty = 1'b0; tx_level = 5'd1; end
        cycles(2);
        @(negedge clk) begin tx_empty = 1'b1; tx_level = 5'd0; end
        cycles(2);
        ticks(HOLD);
        check_code("R4 raise after one-char fill", 4'b0010);
        pulse(thr_wr);
        check_code("R6 write clears", 4'b0001);
        ticks(HOLD + 2);
        check_code("R6 stays clear while empty", 4'b0001);

        // R5: two characters held then empty -> immediate
        @(negedge clk) begin tx_empty = 1'b0; tx_level = 5'd1; end
        @(negedge clk) tx_level = 5'd2;
        @(negedge clk) tx_level = 5'd1;
        @(negedge clk) begin tx_empty = 1'b1; tx_level = 5'd0; end
        cycles(1);
        check_code("R5 immediate raise", 4'b0010);
        pulse(thr_wr);

        // R10: history forgotten after raise
        @(negedge clk) begin tx_empty = 1'b0; tx_level = 5'd1; end
        @(negedge clk) begin tx_empty = 1'b1; tx_level = 5'd0; end
        cycles(2);
        check_code("R10 no immediate raise", 4'b0001);
        ticks(HOLD);
        check_code("R10 raise after full delay", 4'b0010);

        // R2: modem below transmit empty
        pin_then_wait(cts_pin, 1'b1);
        check_code("R2 modem below transmit empty", 4'b0010);
        pulse(iir_rd);
        check_code("R2 modem shown", 4'b0000);
        check_delta("R8 CTS change bit0", 4'b0001);
        pulse(msr_rd);
        check_code("R9 read clears modem", 4'b0001);
        check_delta("R9 delta cleared", 4'b0000);

        // R8: latency and per-pin bits
        @(negedge clk) dsr_pin = 1'b1;
        cycles(2);
        check_delta("R8 latency not yet", 4'b0000);
        cycles(1);
        check_delta("R8 DSR change bit1", 4'b0010);
        pulse(msr_rd);
        pin_then_wait(ri_pin, 1'b1);
        check_delta("R8 RI rise bit2", 4'b0100);
        pulse(msr_rd);
        pin_then_wait(ri_pin, 1'b0);
        check_delta("R8 RI fall ignored", 4'b0000);
        check_code("R8 RI fall no interrupt", 4'b0001);
        pin_then_wait(dcd_pin, 1'b1);
        check_delta("R8 DCD change bit3", 4'b1000);
        pulse(msr_rd);

        // R9: change coinciding with read is kept
        pin_then_wait(cts_pin, 1'b0);
        check_delta("R9 setup CTS", 4'b0001);
        @(negedge clk) dsr_pin = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) msr_rd = 1'b1;
        @(posedge clk);
        #1 msr_rd = 1'b0;
        check_delta("R9 coincident change kept", 4'b0010);
        check_code("R9 modem still pending", 4'b0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule